// File: doc/BRIEF.md
# Fractional pulse-swallowing clock scaler

This block turns a fast parent clock into a lower-rate clock enable by letting through a programmable share of the parent pulses in every window of 32 parent cycles and removing the others. The share is set by a five-bit field. A field value F lets through 32 − F pulses per window, so the output rate is parent_rate × (32 − F) / 32. A field of 0 gives the full parent rate and a field of 31 gives one pulse in 32.

Software writes the field into a rate register. The value stays pending until software sets a kick bit in a separate kick register. Hardware takes the pending value at the next window boundary and then clears the kick bit, so software can poll for a cleared bit to know the new rate is in force. While a kick is pending, the rate register is locked against writes. The passed pulses are spread evenly over each window by an accumulator that adds the multiplier modulo 32 and raises the enable on each carry.

Top module: `frac_clk_scaler`

## Requirements
- R1: After reset, the rate register (address 0) and the kick register (address 1) both read 0, and the enable is high in every cycle of the first window.
- R2: With no kick pending, a write to address 0 stores all 32 data bits and they read back unchanged. The rate field is bits 12:8.
- R3: A write to address 1 stores bits 30:0 as written. Writing 1 to bit 31 (the kick bit) sets it. Writing 0 to bit 31 leaves it as it was, and the active ratio does not change.
- R4: Windows are 32 cycles long. The first window starts in the first cycle after reset is released. The enable is high in exactly 32 − F cycles of each window, where F is the active field.
- R5: In phase p (0..31) of a window with multiplier m = 32 − F, the enable is high exactly when floor((p+1)·m/32) − floor(p·m/32) is 1.
- R6: A kicked value becomes active only at a window boundary: from phase 0 of the first window whose preceding cycle (phase 31) already saw the kick bit set. A kick written during phase 31 leaves the whole next window at the old ratio.
- R7: The kick bit still reads 1 in phase 0 of the window where the new ratio starts, and reads 0 from phase 1.
- R8: While the kick bit is 1, writes to address 0 are ignored entirely, and the ratio that gets adopted is the one pending when the kick was set.
- R9: Addresses 2 and 3 read 0, and writes to them change no register.
- R10: A field written to address 0 without a kick does not change the active ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| clk_en | output | 1 | Scaled clock enable, one parent cycle per pulse |

## Verification
The enable is checked phase by phase over whole windows for fields 0, 1, 5, 16, 24 and 31. Field 0 shows that nothing is removed. Fields 1 and 31 are the extremes: one pulse dropped, and one pulse kept. Field 16 gives a strict alternation. Fields 5 and 24 have uneven spacing, which shows whether the carries are spread evenly or bunched together. Kicks are issued mid-window and in the last phase of a window, which separates adoption at the next boundary from adoption one window later. A rate write made while a kick is pending confirms that the locked value, and not the later one, is what gets adopted.

// File: rtl/scaler_pkg.sv
// Shared constants and types for the fractional clock scaler.
// Assumes a two-bit word address space with two live registers.
package scaler_pkg;
    localparam int RATE_IDX = 0;
    localparam int KICK_IDX = 1;

    // Decoded register selection.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RATE = 2'd1,
        SEL_KICK = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/scaler_regs.sv
// Register file: rate register, kick register and read mux.
// The rate register locks while the kick bit is set. The kick bit is set
// only by software and cleared only by the window sequencer.
module scaler_regs
    import scaler_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 5,
    parameter int KICK_BIT  = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               kick_clr,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [DATA_W-1:0]  rate_q,
    output logic               kick_q,
    output logic [FIELD_W-1:0] pend_field
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] ctl_d;

    // Decode the word address.
    always_comb begin
        if (reg_addr == ADDR_W'(RATE_IDX))      sel = SEL_RATE;
        else if (reg_addr == ADDR_W'(KICK_IDX)) sel = SEL_KICK;
        else                                    sel = SEL_NONE;
    end

    // Rate register: stores whole words, but only while no kick is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rate_q <= '0;
        else if (reg_wr && sel == SEL_RATE && !kick_q)
            rate_q <= reg_wdata;
    end

    // Kick register next state: kick bit sets on 1, ignores 0, clears from hardware.
    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && sel == SEL_KICK) begin
            ctl_d           = reg_wdata;
            ctl_d[KICK_BIT] = ctl_q[KICK_BIT] | reg_wdata[KICK_BIT];
        end
        if (kick_clr)
            ctl_d[KICK_BIT] = 1'b0;
    end

    // Kick register state.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Read mux; unmapped addresses read zero.
    always_comb begin
        case (sel)
            SEL_RATE: reg_rdata = rate_q;
            SEL_KICK: reg_rdata = ctl_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign kick_q     = ctl_q[KICK_BIT];
    assign pend_field = rate_q[FIELD_LSB +: FIELD_W];
endmodule

// File: rtl/scaler_window.sv
// Window sequencer: counts phases of a 2**FIELD_W cycle window, adopts the
// pending field at the last phase when a kick is set, and pulses the clear
// request one cycle later.
// Assumes the pending field is held stable while the kick bit is set.
module scaler_window #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kick_q,
    input  logic [FIELD_W-1:0] pend_field,
    output logic [FIELD_W-1:0] phase,
    output logic [FIELD_W-1:0] active_field,
    output logic               kick_clr
);
    localparam int WIN = 2 ** FIELD_W;

    logic last_phase;
    assign last_phase = (phase == FIELD_W'(WIN - 1));

    // Phase counter, wraps naturally at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // Adopt the pending field at the window boundary when a kick is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_field <= '0;
        else if (last_phase && kick_q)
            active_field <= pend_field;
    end

    // Clear request, issued on the cycle after adoption.
    always_ff @(posedge clk) begin
        if (!rst_n) kick_clr <= 1'b0;
        else        kick_clr <= last_phase && kick_q;
    end
endmodule

// File: rtl/scaler_accum.sv
// Pulse spreader: adds the multiplier (window length minus field) to an
// accumulator modulo the window length, and raises the enable on carry.
// Assumes the field only changes at a window boundary, where the
// accumulator has returned to zero.
module scaler_accum #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] active_field,
    output logic               clk_en
);
    localparam int WIN   = 2 ** FIELD_W;
    localparam int SUM_W = FIELD_W + 1;

    logic [FIELD_W-1:0] acc_q;
    logic [SUM_W-1:0]   mult;
    logic [SUM_W-1:0]   sum;

    // Multiplier and running sum; carry out of the field width is the enable.
    always_comb begin
        mult = SUM_W'(WIN) - {1'b0, active_field};
        sum  = {1'b0, acc_q} + mult;
    end

    assign clk_en = sum[FIELD_W];

    // Accumulator keeps the remainder modulo the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[FIELD_W-1:0];
    end
endmodule

// File: rtl/frac_clk_scaler.sv
// Top: fractional pulse-swallowing clock scaler with a kick handshake.
// Assumes one-cycle write strobes and a combinational read port.
module frac_clk_scaler #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = 5,
    parameter int KICK_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);
    logic [DATA_W-1:0]  rate_q;
    logic               kick_q;
    logic               kick_clr;
    logic [FIELD_W-1:0] pend_field;
    logic [FIELD_W-1:0] phase;
    logic [FIELD_W-1:0] active_field;

    scaler_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB),
        .FIELD_W(FIELD_W), .KICK_BIT(KICK_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .kick_clr(kick_clr), .reg_rdata(reg_rdata),
        .rate_q(rate_q), .kick_q(kick_q), .pend_field(pend_field)
    );

    scaler_window #(.FIELD_W(FIELD_W)) u_window (
        .clk(clk), .rst_n(rst_n), .kick_q(kick_q), .pend_field(pend_field),
        .phase(phase), .active_field(active_field), .kick_clr(kick_clr)
    );

    scaler_accum #(.FIELD_W(FIELD_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .active_field(active_field), .clk_en(clk_en)
    );
endmodule

// File: rtl/scaler_checker.sv
// Property checker for frac_clk_scaler, attached by bind.
module scaler_checker #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int FIELD_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  rate_q,
    input logic               kick_q,
    input logic [FIELD_W-1:0] phase,
    input logic [FIELD_W-1:0] active_field,
    input logic               clk_en
);
    localparam int WIN = 2 ** FIELD_W;

    assert_rate_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(0) && !kick_q) |=> (rate_q == $past(reg_wdata)));

    assert_kick_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[DATA_W-1] && !kick_q) |=> kick_q);

    assert_full_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_field == '0) |-> clk_en);

    assert_adopt_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_field) |-> ($past(phase) == FIELD_W'(WIN - 1)));

    assert_kick_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick_q) |-> ($past(phase) == '0));

    assert_rate_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(0) && kick_q) |=> $stable(rate_q));
endmodule

bind frac_clk_scaler scaler_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rate_q(rate_q), .kick_q(kick_q), .phase(phase),
    .active_field(active_field), .clk_en(clk_en)
);

// File: tb/test_frac_clk_scaler.sv
`timescale 1ns/1ps
module test_frac_clk_scaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    logic [4:0] ph;

    frac_clk_scaler i_frac_clk_scaler (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
    );

    always #2 clk = ~clk;

    // Window phase as defined by R4: phase 0 is the first cycle after reset.
    always @(posedge clk) begin
        if (!rst_n) ph <= 5'd0;
        else        ph <= ph + 5'd1;
    end

    // Vector table: {field[10:6], enables per window[5:0]}.
    localparam logic [10:0] VECS [0:5] = '{
        {5'd0, 6'd32}, {5'd1, 6'd31}, {5'd16, 6'd16},
        {5'd31, 6'd1}, {5'd24, 6'd8}, {5'd5, 6'd27}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_phase(input int p);
        while (int'(ph) != p) @(negedge clk);
    endtask

    // Observe one full window from phase 0; return pattern mismatches,
    // enable count and kick bit at phases 0 and 1.
    task automatic observe(input int m, output int mism, output int cnt,
                           output logic k0, output logic k1);
        logic [31:0] d;
        mism = 0; cnt = 0; k0 = 1'b0; k1 = 1'b0;
        for (int p = 0; p < 32; p++) begin
            int e;
            if (p == 0) begin rd(2'd1, d); k0 = d[31]; end
            if (p == 1) begin rd(2'd1, d); k1 = d[31]; end
            e = (((p + 1) * m) / 32) - ((p * m) / 32);
            if (clk_en) cnt++;
            if (clk_en !== (e != 0)) mism++;
            @(negedge clk);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int mism, cnt;
        logic k0, k1;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and full rate in the first window.
        rd(2'd0, d); check(d == 32'd0, "R1 rate reg reset", d, 32'd0);
        rd(2'd1, d); check(d == 32'd0, "R1 kick reg reset", d, 32'd0);
        observe(32, mism, cnt, k0, k1);
        check(cnt == 32 && mism == 0, "R1 full rate after reset", cnt, 32);

        // R10: pending field without kick leaves the ratio alone.
        wr(2'd0, 32'h0000_1000);
        wait_phase(0);
        observe(32, mism, cnt, k0, k1);
        check(cnt == 32, "R10 no kick no change", cnt, 32);
        check(k0 == 1'b0, "R10 kick stays clear", k0, 0);

        // R9: unmapped addresses.
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, d); check(d == 32'd0, "R9 addr2 reads zero", d, 0);
        rd(2'd3, d); check(d == 32'd0, "R9 addr3 reads zero", d, 0);
        rd(2'd0, d); check(d == 32'h0000_1000, "R9 rate reg untouched", d, 32'h0000_1000);
        rd(2'd1, d); check(d == 32'd0, "R9 kick reg untouched", d, 0);

        // R3: writing 0 to the kick bit has no effect; low bits stored.
        wr(2'd1, 32'h0000_00FF);
        rd(2'd1, d); check(d == 32'h0000_00FF, "R3 kick zero write", d, 32'h0000_00FF);
        wait_phase(0);
        observe(32, mism, cnt, k0, k1);
        check(cnt == 32, "R3 ratio unchanged after zero kick", cnt, 32);

        // Table walk: R2, R3, R4, R5, R7 for each field.
        for (int i = 0; i < 6; i++) begin
            int f, c;
            logic [31:0] wv;
            f = int'(VECS[i][10:6]);
            c = int'(VECS[i][5:0]);
            wait_phase(2);
            wv = 32'h5A00_0000 | (32'(f) << 8) | 32'(i);
            wr(2'd0, wv);
            rd(2'd0, d); check(d == wv, "R2 rate readback", d, wv);
            wr(2'd1, 32'h8000_0000 | 32'(i));
            rd(2'd1, d); check(d == (32'h8000_0000 | 32'(i)), "R3 kick set", d, 32'h8000_0000 | 32'(i));
            wait_phase(0);
            observe(32 - f, mism, cnt, k0, k1);
            check(cnt == c, "R4 enables per window", cnt, c);
            check(mism == 0, "R5 even spread", mism, 0);
            check(k0 == 1'b1 && k1 == 1'b0, "R7 kick clear timing", {k0, k1}, 2'b10);
        end

        // R8: rate register locked while kick pending.
        wait_phase(2);
        wr(2'd0, 32'h0000_0800);
        wr(2'd1, 32'h8000_0000);
        wr(2'd0, 32'h1234_0300);
        rd(2'd0, d); check(d == 32'h0000_0800, "R8 rate write ignored", d, 32'h0000_0800);
        wr(2'd1, 32'h0000_0123);
        rd(2'd1, d); check(d == 32'h8000_0123, "R3 zero kick while pending", d, 32'h8000_0123);
        wait_phase(0);
        observe(24, mism, cnt, k0, k1);
        check(cnt == 24 && mism == 0, "R8 locked value adopted", cnt, 24);

        // R6: kick written in phase 31 defers a whole window.
        wait_phase(3);
        wr(2'd0, 32'h0000_1400);
        wait_phase(31);
        wr(2'd1, 32'h8000_0000);
        observe(24, mism, cnt, k0, k1);
        check(cnt == 24 && mism == 0, "R6 old ratio kept one window", cnt, 24);
        check(k0 == 1'b1 && k1 == 1'b1, "R6 kick still pending", {k0, k1}, 2'b11);
        observe(12, mism, cnt, k0, k1);
        check(cnt == 12 && mism == 0, "R6 new ratio at next boundary", cnt, 12);
        check(k0 == 1'b1 && k1 == 1'b0, "R7 kick clear after deferred adopt", {k0, k1}, 2'b10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule